// File: doc/BRIEF.md
# Majority-Vote Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Every lookup picks one of two methods. The dynamic method reads a per-branch history of recent outcomes from a table and takes a majority vote over it. The static method decides from the sign of the branch displacement and a one-bit compiler hint. The prediction is combinational in the lookup cycle, so fetch logic can use it at once.

Outcomes come back on two resolve slots. The history table has a single write port, so at most one outcome is written per cycle. When both slots are valid together, slot 0 (the older branch) is written and slot 1 is discarded. A one-cycle pulse reports each discard.

The table holds 256 entries of three bits each. It is indexed by PC bits [9:2], so the word offset below bit 2 and all bits above bit 9 play no part in the index.

Top module: `mv_branch_predictor`

## Requirements
- R1: The table entry is selected by PC bits [9:2]. Two PCs that agree in bits [9:2] share one entry. PCs that differ there use separate entries.
- R2: After reset every entry holds 000, so every dynamic lookup predicts not taken (pred_taken_o = 0) until outcomes are recorded.
- R3: A recorded outcome enters its entry as the newest bit and the oldest bit is discarded. The change is visible to lookups from the cycle after the resolve.
- R4: A dynamic lookup (lk_dyn_i = 1) predicts taken exactly when at least two of the entry's three recorded outcomes were taken.
- R5: A static lookup (lk_dyn_i = 0) with lk_hint_i = 0 predicts taken for a backward branch (lk_back_i = 1, negative displacement) and not taken for a forward branch (lk_back_i = 0).
- R6: In a static lookup, lk_hint_i = 1 inverts the direction default, so pred_taken_o = lk_back_i XOR lk_hint_i. A static lookup ignores the table contents.
- R7: Only lk_dyn_i chooses the method: 1 selects the table vote and 0 selects the static rule, for the same PC and table state.
- R8: When both resolve slots are valid in one cycle, slot 0's outcome is recorded and slot 1's outcome has no effect on any entry.
- R9: upd_drop_o is 1 for exactly the one cycle after a cycle in which both resolve slots were valid, and 0 in every other cycle.
- R10: A dynamic lookup in the same cycle as a recorded outcome for the same entry returns the prediction from the entry's contents before that outcome.
- R11: A resolve on slot 1 alone, with slot 0 idle, is recorded like a slot 0 resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | 32 | Lookup branch address |
| lk_back_i | input | 1 | Displacement sign, 1 = backward branch |
| lk_hint_i | input | 1 | Compiler hint, 1 = invert the static default |
| lk_dyn_i | input | 1 | Method select, 1 = dynamic, 0 = static |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| rs0_valid_i | input | 1 | Resolve slot 0 valid (older branch) |
| rs0_pc_i | input | 32 | Resolve slot 0 branch address |
| rs0_taken_i | input | 1 | Resolve slot 0 actual outcome |
| rs1_valid_i | input | 1 | Resolve slot 1 valid (younger branch) |
| rs1_pc_i | input | 32 | Resolve slot 1 branch address |
| rs1_taken_i | input | 1 | Resolve slot 1 actual outcome |
| upd_drop_o | output | 1 | Pulse: slot 1 outcome was discarded |

## Verification
History is visible only through dynamic lookups, and a vote hides some errors. A wrong bit order or a lost write may not change the prediction until one or two more outcomes reach the same entry. The bench therefore drives each targeted entry to vote thresholds such as 011 and 110, where one wrong bit flips pred_taken_o on the next lookup. Wrong arbitration shows up in two ways. upd_drop_o is wrong one cycle after the colliding resolves. The entry of the slot that should have been discarded predicts wrongly on its next dynamic lookup. A long random phase on a few aliased entries compares every cycle with a behavioural model, so a corrupted entry is caught at its next lookup.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned BP_PC_W   = 32;
  localparam int unsigned BP_IDX_W  = 8;
  localparam int unsigned BP_IDX_LSB = 2;
  localparam int unsigned BP_HIST_W = 3;

  typedef enum logic {
    MODE_STATIC  = 1'b0,
    MODE_DYNAMIC = 1'b1
  } bp_mode_e;
endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned IDX_W  = bp_pkg::BP_IDX_W,
  parameter int unsigned HIST_W = bp_pkg::BP_HIST_W,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_taken_i
);
  logic [ENTRIES-1:0][HIST_W-1:0] hist_q;

  // read is combinational: same-cycle write is not forwarded
  assign rd_hist_o = hist_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (wr_en_i) begin
      hist_q[wr_idx_i] <= {hist_q[wr_idx_i][HIST_W-2:0], wr_taken_i};
    end
  end

  assert_newest_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> hist_q[$past(wr_idx_i)][0] == $past(wr_taken_i));

  assert_shift_age_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> hist_q[$past(wr_idx_i)][HIST_W-1:1] == $past(hist_q[wr_idx_i][HIST_W-2:0]));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(hist_q));
endmodule

// File: rtl/bp_dyn_vote.sv
module bp_dyn_vote #(
  parameter int unsigned HIST_W = bp_pkg::BP_HIST_W,
  localparam int unsigned CNT_W = $clog2(HIST_W + 1)
) (
  input  logic [HIST_W-1:0] hist_i,
  output logic              taken_o
);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < HIST_W; i++) begin
      ones = ones + CNT_W'(hist_i[i]);
    end
    taken_o = (ones > CNT_W'(HIST_W / 2));
  end

  always_comb begin
    if (&hist_i) assert_all_taken_R4: assert (taken_o);
    if (hist_i == '0) assert_none_taken_R4: assert (!taken_o);
  end
endmodule

// File: rtl/bp_upd_arb.sv
module bp_upd_arb #(
  parameter int unsigned PC_W    = bp_pkg::BP_PC_W,
  parameter int unsigned IDX_W   = bp_pkg::BP_IDX_W,
  parameter int unsigned IDX_LSB = bp_pkg::BP_IDX_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rs0_valid_i,
  input  logic [PC_W-1:0]  rs0_pc_i,
  input  logic             rs0_taken_i,
  input  logic             rs1_valid_i,
  input  logic [PC_W-1:0]  rs1_pc_i,
  input  logic             rs1_taken_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             wr_taken_o,
  output logic             drop_o
);
  logic collide;
  logic drop_q;
  logic unused_rs_pc;

  assign unused_rs_pc = ^{rs0_pc_i, rs1_pc_i};
  assign collide = rs0_valid_i & rs1_valid_i;

  // older slot wins the single write port
  always_comb begin
    wr_en_o    = rs0_valid_i | rs1_valid_i;
    wr_idx_o   = rs0_valid_i ? rs0_pc_i[IDX_LSB +: IDX_W] : rs1_pc_i[IDX_LSB +: IDX_W];
    wr_taken_o = rs0_valid_i ? rs0_taken_i : rs1_taken_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= collide;
  end

  assign drop_o = drop_q;

  assert_drop_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(rs0_valid_i && rs1_valid_i));

  assert_drop_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs0_valid_i && rs1_valid_i) |=> drop_o);

  assert_slot0_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs0_valid_i |-> (wr_en_o && wr_idx_o == rs0_pc_i[IDX_LSB +: IDX_W]));
endmodule

// File: rtl/mv_branch_predictor.sv
module mv_branch_predictor #(
  parameter int unsigned PC_W    = bp_pkg::BP_PC_W,
  parameter int unsigned IDX_W   = bp_pkg::BP_IDX_W,
  parameter int unsigned IDX_LSB = bp_pkg::BP_IDX_LSB,
  parameter int unsigned HIST_W  = bp_pkg::BP_HIST_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  input  logic            lk_back_i,
  input  logic            lk_hint_i,
  input  logic            lk_dyn_i,
  output logic            pred_taken_o,
  input  logic            rs0_valid_i,
  input  logic [PC_W-1:0] rs0_pc_i,
  input  logic            rs0_taken_i,
  input  logic            rs1_valid_i,
  input  logic [PC_W-1:0] rs1_pc_i,
  input  logic            rs1_taken_i,
  output logic            upd_drop_o
);
  import bp_pkg::*;

  logic [IDX_W-1:0]  rd_idx;
  logic [HIST_W-1:0] rd_hist;
  logic              dyn_taken;
  logic              stat_taken;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_taken;
  logic              unused_lk_pc;
  bp_mode_e          mode;

  assign unused_lk_pc = ^lk_pc_i;
  assign rd_idx = lk_pc_i[IDX_LSB +: IDX_W];
  assign mode   = bp_mode_e'(lk_dyn_i);

  bp_upd_arb #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rs0_valid_i (rs0_valid_i),
    .rs0_pc_i    (rs0_pc_i),
    .rs0_taken_i (rs0_taken_i),
    .rs1_valid_i (rs1_valid_i),
    .rs1_pc_i    (rs1_pc_i),
    .rs1_taken_i (rs1_taken_i),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_taken_o  (wr_taken),
    .drop_o      (upd_drop_o)
  );

  bp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_hist_o  (rd_hist),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_taken_i (wr_taken)
  );

  bp_dyn_vote #(.HIST_W(HIST_W)) u_vote (
    .hist_i  (rd_hist),
    .taken_o (dyn_taken)
  );

  // backward default, hint flips it
  assign stat_taken = lk_back_i ^ lk_hint_i;

  always_comb begin
    unique case (mode)
      MODE_DYNAMIC: pred_taken_o = dyn_taken;
      default:      pred_taken_o = stat_taken;
    endcase
  end

  assert_static_ignores_table_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lk_dyn_i && $stable(lk_back_i) && $stable(lk_hint_i) && $stable(lk_dyn_i))
      |-> $stable(pred_taken_o));
endmodule

// File: tb/mv_branch_predictor_tb_top.sv
module mv_branch_predictor_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        lk_back_i = 1'b0, lk_hint_i = 1'b0, lk_dyn_i = 1'b0;
  logic        pred_taken_o;
  logic        rs0_valid_i = 1'b0, rs0_taken_i = 1'b0;
  logic [31:0] rs0_pc_i = '0;
  logic        rs1_valid_i = 1'b0, rs1_taken_i = 1'b0;
  logic [31:0] rs1_pc_i = '0;
  logic        upd_drop_o;

  always #4 clk_i = ~clk_i;

  mv_branch_predictor dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_pc_i(lk_pc_i), .lk_back_i(lk_back_i), .lk_hint_i(lk_hint_i), .lk_dyn_i(lk_dyn_i),
    .pred_taken_o(pred_taken_o),
    .rs0_valid_i(rs0_valid_i), .rs0_pc_i(rs0_pc_i), .rs0_taken_i(rs0_taken_i),
    .rs1_valid_i(rs1_valid_i), .rs1_pc_i(rs1_pc_i), .rs1_taken_i(rs1_taken_i),
    .upd_drop_o(upd_drop_o)
  );

  // behavioural model: per-entry queue of recent outcomes, newest at back
  bit   hist_m [256][$];
  bit   drop_m = 1'b0;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  function automatic int idx_of(input logic [31:0] pc);
    return int'(pc[9:2]);
  endfunction

  function automatic bit pred_m(input logic [31:0] pc, input bit back, input bit hint, input bit dyn);
    int ones = 0;
    if (!dyn) return back ^ hint;
    foreach (hist_m[idx_of(pc)][k]) ones += int'(hist_m[idx_of(pc)][k]);
    return ones >= 2;
  endfunction

  function automatic void record(input logic [31:0] pc, input bit t);
    hist_m[idx_of(pc)].push_back(t);
    if (hist_m[idx_of(pc)].size() > 3) void'(hist_m[idx_of(pc)].pop_front());
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit dyn, input logic [31:0] lpc, input bit back, input bit hint,
                      input bit v0, input logic [31:0] p0, input bit t0,
                      input bit v1, input logic [31:0] p1, input bit t1, input string tag);
    @(negedge clk_i);
    check("R9 drop pulse", upd_drop_o, drop_m);
    lk_dyn_i = dyn; lk_pc_i = lpc; lk_back_i = back; lk_hint_i = hint;
    rs0_valid_i = v0; rs0_pc_i = p0; rs0_taken_i = t0;
    rs1_valid_i = v1; rs1_pc_i = p1; rs1_taken_i = t1;
    #1;
    check(tag, pred_taken_o, pred_m(lpc, back, hint, dyn));
    @(posedge clk_i);
    drop_m = v0 && v1;
    if (v0) record(p0, t0);
    else if (v1) record(p1, t1);
  endtask

  task automatic look(input logic [31:0] pc, input string tag);
    step(1, pc, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic res0(input logic [31:0] pc, input bit t);
    step(0, 0, 0, 0, 1, pc, t, 0, 0, 0, "R3 resolve cycle");
  endtask

  localparam logic [31:0] PA = 32'h0000_1040;
  localparam logic [31:0] PB = 32'h0000_2080;
  localparam logic [31:0] PC = 32'h0000_30c0;

  initial begin
    #20 rst_ni = 1'b1;
    // R2: cleared table, not taken everywhere
    look(PA, "R2 reset entry A");
    look(PB, "R2 reset entry B");
    look(32'hffff_fffc, "R2 reset top entry");
    // R5 / R6 static rule
    step(0, PA, 1, 0, 0, 0, 0, 0, 0, 0, "R5 backward taken");
    step(0, PA, 0, 0, 0, 0, 0, 0, 0, 0, "R5 forward not taken");
    step(0, PA, 1, 1, 0, 0, 0, 0, 0, 0, "R6 hint backward");
    step(0, PA, 0, 1, 0, 0, 0, 0, 0, 0, "R6 hint forward");
    // R3 / R4 history walk on A: 001,011,110,100
    res0(PA, 1);
    look(PA, "R4 one taken of three");
    res0(PA, 1);
    look(PA, "R4 011 taken");
    res0(PA, 0);
    look(PA, "R3 110 still taken");
    // R10: lookup during update to same entry sees 110 (taken), update makes 100
    step(1, PA, 0, 0, 1, PA, 0, 0, 0, 0, "R10 pre-update value");
    look(PA, "R3 100 not taken");
    // R1 aliasing
    res0(PA, 1); res0(PA, 1);
    look(PA | 32'h0000_0400, "R1 alias above bit 9");
    look(PA | 32'h0000_0003, "R1 word offset ignored");
    look(PA + 32'd4, "R1 neighbour entry");
    // R7: same PC and state, method chosen by select
    step(0, PA, 0, 0, 0, 0, 0, 0, 0, 0, "R7 static over taken entry");
    step(1, PA, 0, 0, 0, 0, 0, 0, 0, 0, "R7 dynamic same entry");
    // R8 / R9: preload B,C with 001, then collide
    res0(PB, 1); res0(PC, 1);
    step(0, 0, 0, 0, 1, PB, 1, 1, PC, 1, "R8 collide cycle");
    look(PB, "R8 slot0 recorded");
    look(PC, "R8 slot1 dropped");
    look(PC, "R9 no second pulse");
    // R11: slot1 alone recorded
    step(0, 0, 0, 0, 0, 0, 0, 1, PC, 1, "R11 slot1 alone");
    look(PC, "R11 slot1 recorded");
    // random mix on a few entries with aliases
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pcs [4];
      pcs[0] = PA; pcs[1] = PB; pcs[2] = PA | 32'h0001_0000; pcs[3] = PC;
      step(bit'($urandom_range(0, 3) != 0), pcs[$urandom_range(0, 3)],
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), pcs[$urandom_range(0, 3)], bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), pcs[$urandom_range(0, 3)], bit'($urandom_range(0, 1)),
           "R4 random dynamic/static");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 final idle");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule